// File: doc/BRIEF.md
# Double-Buffered Gate Schedule Sequencer

This block gates the eight transmit priority queues of one switch port against a cyclic schedule. The schedule is a list of gate commands in a local command RAM. Each command carries an 8-bit allow mask, one bit per queue, and a fetch count in transfer units. The count is consumed one unit per byte-time on a gigabit link. On a 10/100 link it is consumed in nibbles, which is two units per byte-time. An external time base sends a cycle-start pulse that restarts the list at its first entry.

The RAM holds two banks. Software fills the idle bank through the write port while the sequencer executes the other one. Asking for the other bank only records the request. The sequencer moves to it at the next cycle start, so a running cycle never mixes the two schedules. A status output shows which bank is executing, and this can differ from the requested bank. A single-bank option joins both halves into one long list.

The block also raises two sticky error flags. One reports a cycle that was cut short while a command was still counting. The other reports a list that ran off the end of its storage.

Top module: `gate_list_sequencer`

## Requirements
- R1: While either enable input is low, `gate_allow` is 8'hFF and both error flags are 0. After both enables go high, `gate_allow` stays 8'hFF until the first `cycle_start`.
- R2: A command word holds its fetch count in bits 21:8 and its allow mask in bits 7:0. On the clock edge where `cycle_start` is sampled high, entry 0 of the active bank is loaded, and its mask appears on `gate_allow` after that edge.
- R3: When a `unit_tick` uses up the remaining count of a command, the next entry's mask appears on `gate_allow` after that same edge.
- R4: A command whose count is zero ends the list. Its mask is held, with no error, until the next `cycle_start`.
- R5: With `nibble_mode` = 1, each `unit_tick` takes two units from the count. With `nibble_mode` = 0 it takes one.
- R6: In two-bank mode, entry i of bank b is at RAM address b*64 + i. While the sequencer is enabled, a change of `bank_req` takes effect only at the next `cycle_start`. While it is disabled, the change takes effect on the next clock.
- R7: `bank_active` reports the bank the sequencer is currently executing.
- R8: A `cycle_start` that arrives while a command still has count left sets `cnt_err`, and the list restarts at entry 0. `cnt_err` stays set while the sequencer remains enabled.
- R9: If `cycle_start` and a `unit_tick` that drains the last remaining count arrive in the same cycle, `cnt_err` is not set and the list restarts.
- R10: Clearing either enable clears both error flags.
- R11: If the count of entry 63 of a bank runs out and no zero-count command came before it, `addr_err` is set and stays set, and the last mask is held.
- R12: With `single_bank` = 1, the list runs over all 128 entries starting at address 0, `bank_req` is ignored, and `bank_active` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sched_glb_en | input | 1 | Global scheduler enable |
| sched_port_en | input | 1 | Enable for this port |
| single_bank | input | 1 | 1: one 128-entry list; 0: two 64-entry banks |
| bank_req | input | 1 | Requested bank for the next cycle |
| nibble_mode | input | 1 | 1: 10/100 link, two count units per tick |
| cycle_start | input | 1 | Cycle-start pulse from the time base |
| unit_tick | input | 1 | One pulse per byte-time on the line |
| ram_wr_en | input | 1 | Command RAM write strobe |
| ram_wr_addr | input | 7 | Command RAM write address |
| ram_wr_data | input | 22 | Command word: count in 21:8, mask in 7:0 |
| gate_allow | output | 8 | Per-queue allow mask |
| bank_active | output | 1 | Bank currently executing |
| cnt_err | output | 1 | Sticky count error flag |
| addr_err | output | 1 | Sticky address error flag |

## Verification
A cycle-start pulse and a count-consuming tick can land on the same clock. The bench provokes this by driving both on one edge. In one case the pending command has exactly one unit left, so the tick drains it and no count error may appear. In the other case it has two units left, so the count error must be raised. In both cases the bench expects the list to have restarted with entry 0's mask, and it compares `gate_allow` and `cnt_err` at the next falling edge.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

    localparam int unsigned GSQ_QUEUES = 8;
    localparam int unsigned GSQ_CNT_W  = 14;
    localparam int unsigned GSQ_CNT_LSB = GSQ_QUEUES;
    localparam int unsigned GSQ_CMD_W  = GSQ_CNT_LSB + GSQ_CNT_W;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_RUN  = 2'd1,
        GS_HOLD = 2'd2
    } gs_state_e;

    function automatic logic [GSQ_CNT_W-1:0] cmd_count(input logic [GSQ_CMD_W-1:0] w);
        return w[GSQ_CMD_W-1:GSQ_CNT_LSB];
    endfunction

    function automatic logic [GSQ_QUEUES-1:0] cmd_mask(input logic [GSQ_CMD_W-1:0] w);
        return w[GSQ_QUEUES-1:0];
    endfunction

endpackage

// File: rtl/gsq_cmd_ram.sv
module gsq_cmd_ram #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned WORD_W = 22,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/gsq_bank_ctrl.sv
module gsq_bank_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic single_bank,
    input  logic bank_req,
    input  logic cycle_start,
    output logic eff_bank,
    output logic bank_q_o
);

    logic bank_d, bank_q;

    // Bank used for this cycle's read; becomes the registered bank.
    always_comb begin
        if (single_bank) begin
            bank_d = 1'b0;
        end else if (!run || cycle_start) begin
            bank_d = bank_req;
        end else begin
            bank_d = bank_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign eff_bank = bank_d;
    assign bank_q_o = bank_q;

    // R6: a running schedule keeps its bank between cycle starts
    p_swap_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cycle_start && !single_bank) |=> $stable(bank_q));

    // R12: single-bank mode always reports bank 0
    p_single_reports_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        single_bank |=> (bank_q == 1'b0));

endmodule

// File: rtl/gsq_engine.sv
module gsq_engine
    import gsq_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    localparam int unsigned RD_W = IDX_W - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  cycle_start,
    input  logic                  unit_tick,
    input  logic                  nibble_mode,
    input  logic [IDX_W-1:0]      limit,
    input  logic [GSQ_CMD_W-1:0]  rd_word,
    output logic [RD_W-1:0]       rd_idx,
    output logic [GSQ_QUEUES-1:0] allow,
    output logic                  cnt_err,
    output logic                  addr_err
);

    typedef struct packed {
        gs_state_e             st;
        logic [IDX_W-1:0]      idx;
        logic [GSQ_CNT_W-1:0]  cnt;
        logic [GSQ_QUEUES-1:0] allow;
        logic                  cnt_err;
        logic                  addr_err;
    } eng_t;

    eng_t d, q;

    logic [GSQ_CNT_W-1:0]  step;
    logic [GSQ_CNT_W-1:0]  new_cnt;
    logic [GSQ_QUEUES-1:0] new_mask;
    logic                  drain;

    assign step     = nibble_mode ? GSQ_CNT_W'(2) : GSQ_CNT_W'(1);
    assign new_cnt  = cmd_count(rd_word);
    assign new_mask = cmd_mask(rd_word);
    assign drain    = (q.st == GS_RUN) && unit_tick && (q.cnt <= step);
    assign rd_idx   = cycle_start ? '0 : q.idx[RD_W-1:0];

    always_comb begin
        d = q;
        if (!run) begin
            d.st       = GS_IDLE;
            d.idx      = '0;
            d.cnt      = '0;
            d.allow    = '1;
            d.cnt_err  = 1'b0;
            d.addr_err = 1'b0;
        end else if (cycle_start) begin
            if ((q.st == GS_RUN) && !drain) begin
                d.cnt_err = 1'b1;
            end
            d.allow = new_mask;
            d.cnt   = new_cnt;
            d.idx   = IDX_W'(1);
            d.st    = (new_cnt == '0) ? GS_HOLD : GS_RUN;
        end else if ((q.st == GS_RUN) && unit_tick) begin
            if (drain) begin
                if (q.idx >= limit) begin
                    d.addr_err = 1'b1;
                    d.cnt      = '0;
                    d.st       = GS_HOLD;
                end else begin
                    d.allow = new_mask;
                    d.cnt   = new_cnt;
                    d.idx   = q.idx + IDX_W'(1);
                    d.st    = (new_cnt == '0) ? GS_HOLD : GS_RUN;
                end
            end else begin
                d.cnt = q.cnt - step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= GS_IDLE;
            q.idx      <= '0;
            q.cnt      <= '0;
            q.allow    <= '1;
            q.cnt_err  <= 1'b0;
            q.addr_err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign allow    = q.allow;
    assign cnt_err  = q.cnt_err;
    assign addr_err = q.addr_err;

    // R1 / R10: disabled scheduler opens every queue and drops errors
    p_disabled_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q.allow == '1 && !q.cnt_err && !q.addr_err));

    // R4: an ended list keeps its mask until a new cycle
    p_hold_keeps_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == GS_HOLD && run && !cycle_start) |=> $stable(q.allow));

    // R8: count error is sticky while enabled
    p_cnt_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt_err && run) |=> q.cnt_err);

    // R11: address error is sticky while enabled
    p_addr_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.addr_err && run) |=> q.addr_err);

    // R3: a running command never holds a zero count
    p_run_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == GS_RUN) |-> (q.cnt != '0));

endmodule

// File: rtl/gate_list_sequencer.sv
module gate_list_sequencer
    import gsq_pkg::*;
#(
    parameter int unsigned BANK_DEPTH = 64,
    localparam int unsigned RAM_DEPTH = 2 * BANK_DEPTH,
    localparam int unsigned RAM_AW    = $clog2(RAM_DEPTH),
    localparam int unsigned BANK_AW   = $clog2(BANK_DEPTH),
    localparam int unsigned IDX_W     = RAM_AW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sched_glb_en,
    input  logic                  sched_port_en,
    input  logic                  single_bank,
    input  logic                  bank_req,
    input  logic                  nibble_mode,
    input  logic                  cycle_start,
    input  logic                  unit_tick,
    input  logic                  ram_wr_en,
    input  logic [RAM_AW-1:0]     ram_wr_addr,
    input  logic [GSQ_CMD_W-1:0]  ram_wr_data,
    output logic [GSQ_QUEUES-1:0] gate_allow,
    output logic                  bank_active,
    output logic                  cnt_err,
    output logic                  addr_err
);

    logic                 run;
    logic                 eff_bank;
    logic [RAM_AW-1:0]    rd_idx;
    logic [RAM_AW-1:0]    rd_addr;
    logic [GSQ_CMD_W-1:0] rd_word;
    logic [IDX_W-1:0]     limit;

    assign run   = sched_glb_en && sched_port_en;
    assign limit = single_bank ? IDX_W'(RAM_DEPTH) : IDX_W'(BANK_DEPTH);

    // Bank number is the top address bit in two-bank mode.
    assign rd_addr = single_bank ? rd_idx : {eff_bank, rd_idx[BANK_AW-1:0]};

    gsq_cmd_ram #(
        .DEPTH  (RAM_DEPTH),
        .WORD_W (GSQ_CMD_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (ram_wr_en),
        .wr_addr (ram_wr_addr),
        .wr_data (ram_wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    gsq_bank_ctrl u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .single_bank (single_bank),
        .bank_req    (bank_req),
        .cycle_start (cycle_start),
        .eff_bank    (eff_bank),
        .bank_q_o    (bank_active)
    );

    gsq_engine #(
        .IDX_W (IDX_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cycle_start (cycle_start),
        .unit_tick   (unit_tick),
        .nibble_mode (nibble_mode),
        .limit       (limit),
        .rd_word     (rd_word),
        .rd_idx      (rd_idx),
        .allow       (gate_allow),
        .cnt_err     (cnt_err),
        .addr_err    (addr_err)
    );

endmodule

// File: tb/test_gate_list_sequencer.sv
module test_gate_list_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sched_glb_en = 1'b0;
    logic        sched_port_en = 1'b0;
    logic        single_bank = 1'b0;
    logic        bank_req = 1'b0;
    logic        nibble_mode = 1'b0;
    logic        cycle_start = 1'b0;
    logic        unit_tick = 1'b0;
    logic        ram_wr_en = 1'b0;
    logic [6:0]  ram_wr_addr = '0;
    logic [21:0] ram_wr_data = '0;
    logic [7:0]  gate_allow;
    logic        bank_active;
    logic        cnt_err;
    logic        addr_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    gate_list_sequencer i_gate_list_sequencer (
        .clk, .rst_n, .sched_glb_en, .sched_port_en, .single_bank, .bank_req,
        .nibble_mode, .cycle_start, .unit_tick, .ram_wr_en, .ram_wr_addr,
        .ram_wr_data, .gate_allow, .bank_active, .cnt_err, .addr_err
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    endtask

    task automatic wr(input int addr, input int cnt, input int mask);
        ram_wr_en   = 1'b1;
        ram_wr_addr = 7'(addr);
        ram_wr_data = {14'(cnt), 8'(mask)};
        @(negedge clk);
        ram_wr_en   = 1'b0;
    endtask

    task automatic start();
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            unit_tick = 1'b1;
            @(negedge clk);
        end
        unit_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "allow after reset", gate_allow, 8'hFF);
        chk("R7", "bank after reset", bank_active, 0);
        chk("R1", "errors after reset", {cnt_err, addr_err}, 0);
    endtask

    task automatic t_list_bytes();
        wr(0, 16, 8'h01);
        wr(1, 20, 8'h02);
        wr(2, 0, 8'h80);
        sched_glb_en = 1'b1;
        sched_port_en = 1'b1;
        idle(2);
        chk("R1", "open before first start", gate_allow, 8'hFF);
        start();
        chk("R2", "entry0 mask", gate_allow, 8'h01);
        ticks(15);
        chk("R3", "entry0 not yet drained", gate_allow, 8'h01);
        ticks(1);
        chk("R3", "entry1 after drain", gate_allow, 8'h02);
        ticks(20);
        chk("R4", "terminator mask", gate_allow, 8'h80);
        ticks(5);
        chk("R4", "terminator held", gate_allow, 8'h80);
        chk("R4", "no error at end", {cnt_err, addr_err}, 0);
    endtask

    task automatic t_list_nibbles();
        nibble_mode = 1'b1;
        start();
        chk("R5", "entry0 mask", gate_allow, 8'h01);
        ticks(8);
        chk("R5", "16 units in 8 ticks", gate_allow, 8'h02);
        ticks(7);
        chk("R5", "entry1 still counting", gate_allow, 8'h02);
        ticks(3);
        chk("R5", "20 units in 10 ticks", gate_allow, 8'h80);
        chk("R5", "no error", {cnt_err, addr_err}, 0);
        nibble_mode = 1'b0;
    endtask

    task automatic t_bank_swap();
        wr(64, 0, 8'h40);
        bank_req = 1'b1;
        idle(3);
        chk("R6", "request alone keeps bank", bank_active, 0);
        chk("R6", "mask unchanged by request", gate_allow, 8'h80);
        start();
        chk("R7", "bank 1 active", bank_active, 1);
        chk("R6", "bank 1 entry0 mask", gate_allow, 8'h40);
        bank_req = 1'b0;
        idle(2);
        chk("R6", "bank held until start", bank_active, 1);
        start();
        chk("R7", "back to bank 0", bank_active, 0);
        chk("R6", "bank 0 entry0 mask", gate_allow, 8'h01);
        ticks(36);
        chk("R4", "bank 0 finished", gate_allow, 8'h80);
    endtask

    task automatic t_cnt_err();
        start();
        chk("R8", "start after end is clean", cnt_err, 0);
        ticks(5);
        start();
        chk("R8", "cut-short cycle flagged", cnt_err, 1);
        chk("R8", "list restarted", gate_allow, 8'h01);
        ticks(16);
        chk("R8", "restart counts fresh", gate_allow, 8'h02);
        chk("R8", "flag sticky", cnt_err, 1);
    endtask

    task automatic t_coincide();
        sched_glb_en = 1'b0;
        @(negedge clk);
        chk("R10", "errors cleared by disable", {cnt_err, addr_err}, 0);
        chk("R1", "disabled opens queues", gate_allow, 8'hFF);
        sched_glb_en = 1'b1;
        start();
        ticks(15);
        cycle_start = 1'b1;
        unit_tick = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        unit_tick = 1'b0;
        chk("R9", "drain with start: no error", cnt_err, 0);
        chk("R9", "restarted at entry0", gate_allow, 8'h01);
        ticks(14);
        cycle_start = 1'b1;
        unit_tick = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        unit_tick = 1'b0;
        chk("R8", "two left with start: error", cnt_err, 1);
        chk("R8", "restarted at entry0", gate_allow, 8'h01);
    endtask

    task automatic t_addr_err();
        sched_port_en = 1'b0;
        @(negedge clk);
        chk("R10", "port disable clears", {cnt_err, addr_err}, 0);
        for (int i = 0; i < 64; i++) wr(i, 16, i + 1);
        sched_port_en = 1'b1;
        start();
        ticks(64 * 16 - 1);
        chk("R11", "entry63 running", gate_allow, 8'd64);
        chk("R11", "no error before overrun", addr_err, 0);
        ticks(1);
        chk("R11", "overrun flagged", addr_err, 1);
        chk("R11", "mask held", gate_allow, 8'd64);
        ticks(10);
        chk("R11", "still held", gate_allow, 8'd64);
    endtask

    task automatic t_single();
        sched_port_en = 1'b0;
        single_bank = 1'b1;
        bank_req = 1'b1;
        wr(64, 0, 8'h55);
        idle(2);
        chk("R12", "bank reads 0", bank_active, 0);
        sched_port_en = 1'b1;
        start();
        chk("R12", "bank reads 0 running", bank_active, 0);
        ticks(64 * 16);
        chk("R12", "runs into upper half", gate_allow, 8'h55);
        chk("R12", "no address error", addr_err, 0);
        single_bank = 1'b0;
        sched_port_en = 1'b0;
        @(negedge clk);
        chk("R6", "disabled bank follows request", bank_active, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_list_bytes();
        t_list_nibbles();
        t_bank_swap();
        t_cnt_err();
        t_coincide();
        t_addr_err();
        t_single();
        report();
    end

endmodule